// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This block takes a wide fixed-point mantissa that carries two extra low-order bits, guard above round, together with a separate sticky bit, the sign of the value and a two-bit rounding-mode selector. It removes the two extension bits and, depending on the mode, adds one at the new least-significant position. It reports whether the dropped part was nonzero (inexact) and whether the increment happened (rounded up).

The increment carries through the whole 64-bit result. If it carries out of the top, the extra bit is returned as a separate carry output. The block does not correct this carry: renormalising it and packing the exponent are left to the caller.

The unit also reports an overflow policy flag. The flag tells the caller whether an overflowing result should become infinity or the largest finite value, given the active mode and the sign.

The unit has one register stage. Every accepted input produces its results on the clock edge that samples it. The outputs then hold until the next accepted input.

Top module: `mant_round_unit`

## Requirements
- R1: When no increment occurs, `mant_out` equals `mant_in[65:2]`. The sticky bit never changes any bit of `mant_out` except through the rounding decision.
- R2: When `mant_in[1]` (guard), `mant_in[0]` (round) and `sticky_in` are all 0, the result is exact: `inexact` is 0, `rounded_up` is 0 and `carry_out` is 0, in every mode.
- R3: `inexact` is 1 exactly when at least one of guard, round or sticky is 1, whatever the mode.
- R4: In mode 2'b00 (nearest), an increment happens only when guard is 1 and at least one of round, sticky or `mant_in[2]` (the new LSB) is 1. An exact tie therefore goes to the even value.
- R5: In mode 2'b01 (toward zero), no increment ever happens.
- R6: In mode 2'b10 (toward plus infinity), an inexact result is incremented only when `sign_in` is 0. In mode 2'b11 (toward minus infinity), it is incremented only when `sign_in` is 1.
- R7: When an increment happens, `{carry_out, mant_out}` equals `mant_in[65:2] + 1` with the carry taken through all 64 bits. `rounded_up` is 1 exactly when the increment happened. `carry_out` is 1 only when `mant_in[65:2]` is all ones and was incremented.
- R8: `ovf_to_inf` is 1 in mode 2'b00, 0 in mode 2'b01, `!sign_in` in mode 2'b10 and `sign_in` in mode 2'b11.
- R9: An input accepted with `in_valid` = 1 at a rising edge shows on all result outputs and on `out_valid` = 1 right after that same edge. While `in_valid` is 0, the result outputs keep their values and `out_valid` falls to 0.
- R10: While reset is asserted and until the first accepted input, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept the input operand at this edge |
| mant_in | input | 66 | Mantissa with guard at bit 1 and round at bit 0 |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| mode_in | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Results below belong to the input accepted at the last edge |
| mant_out | output | 64 | Shifted and possibly incremented mantissa |
| carry_out | output | 1 | Carry out of the top of the increment (value 2.0 left to caller) |
| inexact | output | 1 | Dropped bits were nonzero |
| rounded_up | output | 1 | The increment was applied |
| ovf_to_inf | output | 1 | Overflow should go to infinity (1) or largest finite value (0) |

## Verification
Every result, including `out_valid`, is due exactly one rising edge after the edge that samples `in_valid` = 1. The bench drives each operand at a falling edge and lowers `in_valid` at the next falling edge. It compares the outputs at that same falling edge, half a cycle after the register has loaded. For the hold behaviour, the bench changes the inputs while `in_valid` is low and compares the outputs again one full cycle later. They must still show the previous result, and `out_valid` must be 0.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } round_mode_e;

  typedef struct packed {
    logic inexact;
    logic incr;
    logic to_inf;
  } round_dec_t;

endpackage

// File: rtl/rnd_reset_sync.sv
module rnd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic       guard_bit,
  input  logic       round_bit,
  input  logic       sticky_bit,
  input  logic       new_lsb,
  input  logic       sign_bit,
  input  logic [1:0] mode,
  output round_dec_t dec
);

  logic any_lost;

  assign any_lost = guard_bit | round_bit | sticky_bit;

  always_comb begin
    dec.inexact = any_lost;
    dec.incr    = 1'b0;
    dec.to_inf  = 1'b1;
    case (round_mode_e'(mode))
      RM_ZERO: begin
        dec.incr   = 1'b0;
        dec.to_inf = 1'b0;
      end
      RM_POS: begin
        dec.incr   = any_lost & ~sign_bit;
        dec.to_inf = ~sign_bit;
      end
      RM_NEG: begin
        dec.incr   = any_lost & sign_bit;
        dec.to_inf = sign_bit;
      end
      default: begin
        dec.incr   = guard_bit & (round_bit | sticky_bit | new_lsb);
        dec.to_inf = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int WIDTH = 64,
  parameter int CHUNK = 16
) (
  input  logic [WIDTH-1:0] val_in,
  input  logic             cin,
  output logic [WIDTH-1:0] val_out,
  output logic             cout
);

  localparam int NCHUNK = WIDTH / CHUNK;

  logic [NCHUNK:0] carry;

  assign carry[0] = cin;

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    logic [CHUNK-1:0] seg;
    logic             all_ones;
    assign seg      = val_in[c*CHUNK +: CHUNK];
    assign all_ones = &seg;
    assign val_out[c*CHUNK +: CHUNK] = seg + {{(CHUNK-1){1'b0}}, carry[c]};
    assign carry[c+1] = carry[c] & all_ones;
  end

  assign cout = carry[NCHUNK];

endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
  import rnd_pkg::*;
#(
  parameter int MANT_W = 64,
  parameter int CHUNK  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W+1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic              out_valid,
  output logic [MANT_W-1:0] mant_out,
  output logic              carry_out,
  output logic              inexact,
  output logic              rounded_up,
  output logic              ovf_to_inf
);

  localparam int IN_W = MANT_W + 2;

  logic              rst_n_int;
  logic [MANT_W-1:0] shifted;
  round_dec_t        dec;
  logic [MANT_W-1:0] sum;
  logic              sum_cout;

  logic              valid_d;
  logic [MANT_W-1:0] mant_d;
  logic              carry_d, inexact_d, up_d, inf_d;

  rnd_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  assign shifted = mant_in[IN_W-1:2];

  rnd_decide u_dec (
    .guard_bit (mant_in[1]),
    .round_bit (mant_in[0]),
    .sticky_bit(sticky_in),
    .new_lsb   (shifted[0]),
    .sign_bit  (sign_in),
    .mode      (mode_in),
    .dec       (dec)
  );

  rnd_incr #(.WIDTH(MANT_W), .CHUNK(CHUNK)) u_inc (
    .val_in (shifted),
    .cin    (dec.incr),
    .val_out(sum),
    .cout   (sum_cout)
  );

  // next-state: load on accepted input, otherwise hold
  always_comb begin
    valid_d   = in_valid;
    mant_d    = mant_out;
    carry_d   = carry_out;
    inexact_d = inexact;
    up_d      = rounded_up;
    inf_d     = ovf_to_inf;
    if (in_valid) begin
      mant_d    = sum;
      carry_d   = sum_cout;
      inexact_d = dec.inexact;
      up_d      = dec.incr;
      inf_d     = dec.to_inf;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid  <= 1'b0;
      mant_out   <= '0;
      carry_out  <= 1'b0;
      inexact    <= 1'b0;
      rounded_up <= 1'b0;
      ovf_to_inf <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      mant_out   <= mant_d;
      carry_out  <= carry_d;
      inexact    <= inexact_d;
      rounded_up <= up_d;
      ovf_to_inf <= inf_d;
    end
  end

endmodule

// File: rtl/mant_round_unit_chk.sv
module mant_round_unit_chk #(
  parameter int MANT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MANT_W+1:0] mant_in,
  input logic              sticky_in,
  input logic              sign_in,
  input logic [1:0]        mode_in,
  input logic              out_valid,
  input logic [MANT_W-1:0] mant_out,
  input logic              carry_out,
  input logic              inexact,
  input logic              rounded_up,
  input logic              ovf_to_inf
);

  // R1: no lost bits -> mantissa is the plain shift
  a_r1_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mant_in[1] && !mant_in[0] && !sticky_in |=> mant_out == $past(mant_in[MANT_W+1:2]));

  // R2: exact input never rounds up
  a_r2_exact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !inexact |-> !rounded_up && !carry_out);

  // R3: inexact follows guard|round|sticky
  a_r3_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> inexact == $past(mant_in[1] | mant_in[0] | sticky_in));

  // R4: nearest without guard does not increment
  a_r4_near_no_guard: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_in == 2'b00 && !mant_in[1] |=> !rounded_up);

  // R5: toward zero never increments
  a_r5_toward_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_in == 2'b01 |=> !rounded_up);

  // R6: directed modes never increment against the sign
  a_r6_pos_neg: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((mode_in == 2'b10 && sign_in) || (mode_in == 2'b11 && !sign_in)) |=> !rounded_up);

  // R7: carry out only as a result of an increment
  a_r7_carry: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> rounded_up);

  // R8: nearest always overflows to infinity
  a_r8_policy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_in == 2'b00 |=> ovf_to_inf);

  // R9: results hold while no input is accepted
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(mant_out) && $stable(rounded_up));

endmodule

bind mant_round_unit mant_round_unit_chk #(.MANT_W(MANT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mant_in   (mant_in),
  .sticky_in (sticky_in),
  .sign_in   (sign_in),
  .mode_in   (mode_in),
  .out_valid (out_valid),
  .mant_out  (mant_out),
  .carry_out (carry_out),
  .inexact   (inexact),
  .rounded_up(rounded_up),
  .ovf_to_inf(ovf_to_inf)
);

// File: tb/test_mant_round_unit.sv
`timescale 1ns/1ps
module test_mant_round_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [65:0] mant_in = '0;
  logic        sticky_in = 1'b0;
  logic        sign_in = 1'b0;
  logic [1:0]  mode_in = 2'b00;
  logic        out_valid;
  logic [63:0] mant_out;
  logic        carry_out, inexact, rounded_up, ovf_to_inf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mant_round_unit i_mant_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mant_in(mant_in),
    .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
    .out_valid(out_valid), .mant_out(mant_out), .carry_out(carry_out),
    .inexact(inexact), .rounded_up(rounded_up), .ovf_to_inf(ovf_to_inf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [65:0] m, input logic s, input logic sg, input logic [1:0] md);
    @(negedge clk);
    mant_in = m; sticky_in = s; sign_in = sg; mode_in = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // reference from the requirements
  task automatic check_model(input string req, input logic [65:0] m, input logic s,
                             input logic sg, input logic [1:0] md);
    logic [63:0] sh;
    logic        g, r, lost, up, inf;
    logic [64:0] res;
    sh = m[65:2]; g = m[1]; r = m[0];
    lost = g | r | s;
    case (md)
      2'b01:   begin up = 1'b0;        inf = 1'b0; end
      2'b10:   begin up = lost & !sg;  inf = !sg;  end
      2'b11:   begin up = lost & sg;   inf = sg;   end
      default: begin up = g & (r | s | sh[0]); inf = 1'b1; end
    endcase
    res = {1'b0, sh} + {64'd0, up};
    apply(m, s, sg, md);
    chk({req, " mant"},    mant_out,            res[63:0]);
    chk({req, " carry"},   {63'd0, carry_out},  {63'd0, res[64]});
    chk({req, " inexact"}, {63'd0, inexact},    {63'd0, lost});
    chk({req, " up"},      {63'd0, rounded_up}, {63'd0, up});
    chk({req, " inf"},     {63'd0, ovf_to_inf}, {63'd0, inf});
    chk({req, " valid"},   {63'd0, out_valid},  64'd1);
  endtask

  function automatic logic [65:0] rnd66();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic t_reset();
    chk("R10 reset mant", mant_out, 64'd0);
    chk("R10 reset flags", {59'd0, out_valid, carry_out, inexact, rounded_up, ovf_to_inf}, 64'd0);
  endtask

  task automatic t_exact();
    for (int md = 0; md < 4; md++) begin
      check_model("R2 exact", {64'hDEAD_BEEF_0123_4567, 2'b00}, 1'b0, md[0], md[1:0]);
      chk("R1 R2 plain shift", mant_out, 64'hDEAD_BEEF_0123_4567);
    end
  endtask

  task automatic t_sticky_only();
    check_model("R1 R3 sticky zero-mode", {64'h0000_0000_0000_00F0, 2'b00}, 1'b1, 1'b0, 2'b01);
    chk("R1 sticky not merged", mant_out, 64'h0000_0000_0000_00F0);
    check_model("R3 sticky near", {64'h0000_0000_0000_00F0, 2'b00}, 1'b1, 1'b0, 2'b00);
    chk("R4 sticky only no incr", {63'd0, rounded_up}, 64'd0);
  endtask

  task automatic t_ties();
    check_model("R4 tie even", {64'h1234_0000_0000_0002, 2'b10}, 1'b0, 1'b0, 2'b00);
    chk("R4 tie to even stays", mant_out, 64'h1234_0000_0000_0002);
    check_model("R4 tie odd", {64'h1234_0000_0000_0003, 2'b10}, 1'b0, 1'b0, 2'b00);
    chk("R4 tie odd rounds", mant_out, 64'h1234_0000_0000_0004);
    check_model("R4 above half", {64'h10, 2'b11}, 1'b0, 1'b0, 2'b00);
    check_model("R4 guard+sticky", {64'h10, 2'b10}, 1'b1, 1'b1, 2'b00);
  endtask

  task automatic t_directed();
    check_model("R6 pos positive", {64'h7, 2'b01}, 1'b0, 1'b0, 2'b10);
    chk("R6 pos up", mant_out, 64'h8);
    check_model("R6 pos negative", {64'h7, 2'b01}, 1'b0, 1'b1, 2'b10);
    check_model("R6 neg negative", {64'h7, 2'b01}, 1'b0, 1'b1, 2'b11);
    chk("R6 neg up", mant_out, 64'h8);
    check_model("R6 neg positive", {64'h7, 2'b01}, 1'b0, 1'b0, 2'b11);
    check_model("R5 zero", {64'h7, 2'b11}, 1'b1, 1'b1, 2'b01);
  endtask

  task automatic t_carry();
    check_model("R7 carry top", {64'hFFFF_FFFF_FFFF_FFFF, 2'b11}, 1'b0, 1'b0, 2'b00);
    chk("R7 wrap to zero", mant_out, 64'd0);
    chk("R7 carry set", {63'd0, carry_out}, 64'd1);
    check_model("R7 chunk carry", {64'h0000_0000_FFFF_FFFF, 2'b10}, 1'b1, 1'b1, 2'b11);
    chk("R7 carry across chunks", mant_out, 64'h0000_0001_0000_0000);
    check_model("R7 all ones zero-mode", {64'hFFFF_FFFF_FFFF_FFFF, 2'b11}, 1'b1, 1'b0, 2'b01);
  endtask

  task automatic t_policy();
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        check_model("R8 policy", {64'h5, 2'b00}, 1'b0, sg[0], md[1:0]);
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    check_model("R9 load", {64'hA5A5_0000_1111_2222, 2'b11}, 1'b0, 1'b0, 2'b00);
    prev = mant_out;
    mant_in = '0; sticky_in = 1'b1; mode_in = 2'b10;
    @(negedge clk);
    chk("R9 hold mant", mant_out, prev);
    chk("R9 hold up", {63'd0, rounded_up}, 64'd1);
    chk("R9 valid low", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [65:0] m;
      m = rnd66();
      if (i % 7 == 0) m[1:0] = 2'b10;
      if (i % 11 == 0) m[65:2] = '1;
      check_model("R4 R5 R6 R7 random", m, (i % 3 == 0), $urandom() & 1, i[1:0]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_exact();
    t_sticky_only();
    t_ties();
    t_directed();
    t_carry();
    t_policy();
    t_hold();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule